// File: doc/BRIEF.md
# Window and Timeout Watchdog Timer

This block checks that a host processor keeps servicing it at acceptable moments. After reset it sits idle. The first service event starts a period timer that counts a slow time base, which arrives as a one-cycle `tick_ms` pulse once per millisecond. From then on, every service event is judged against the elapsed time. The verdict is a one-cycle `good_o` pulse or a one-cycle `err_o` pulse. A separate error-handling block consumes these pulses for counting and escalation.

There are two checking disciplines. In window mode the period is split into a closed first half and an open second half. A service in the closed half is an error, and so is letting the whole period pass with no service. In timeout mode a service is welcome at any moment before the period runs out. Each accepted service restarts the count from zero.

The period is set in one of two ways. A register-style pair of codes (a 3-bit multiplier and a 2-bit prescaler) selects it from a fixed table. Alternatively, a pin-driven select chooses one of three fixed lengths. A service is either a rising edge on the asynchronous `trig_in` pin or a single-cycle `svc_wr` strobe.

Top module: `svc_watchdog`

## Requirements
- R1: After reset `good_o` and `err_o` are 0 and the timer is idle. Neither ticks nor the passage of time cause a pulse while idle. The first service event starts the timer at zero elapsed ticks and itself produces no pulse.
- R2: A service event is a cycle with `svc_wr`=1, or a 0-to-1 change of `trig_in`. The result pulse follows `svc_wr` by one clock. It follows a `trig_in` rise by three clocks (two synchroniser stages plus the result register). Holding `trig_in` high, or lowering it, is no service.
- R3: Elapsed time advances only in clock cycles where `tick_ms`=1.
- R4: With `mode_timeout`=0 (window mode), a service while fewer than P/2 ticks have elapsed gives an `err_o` pulse. P is the period in ticks.
- R5: In window mode, a service when at least P/2 and at most P-1 ticks have elapsed gives a `good_o` pulse.
- R6: In both modes, if no service arrives, `err_o` pulses on the tick that brings the elapsed count to P.
- R7: With `mode_timeout`=1 (timeout mode), any service with at most P-1 ticks elapsed gives a `good_o` pulse.
- R8: After every `good_o` or `err_o` pulse the elapsed count restarts at zero. In window mode this means a fresh closed half follows every pulse, including a pulse for an error.
- R9: With `pin_mode`=0, P in ms comes from {`mult`,`presc`} as follows. Multiplier codes 000, 001, 010, 100 and 101 use base values 4, 32, 128, 512 and 2048, and P is the base times (presc+1). Code 011 gives 256, 384, 512 and 768 for presc 00 to 11. Code 110 gives 10240 for presc 00 and 20240 for presc 01.
- R10: Reserved codes (multiplier 110 with presc 10 or 11, and multiplier 111 with any presc) use the largest legal period, 20240 ms.
- R11: With `pin_mode`=1, `pin_sel` 00 gives 40 ms, 01 gives 600 ms and 10 gives 6000 ms. The reserved value 11 gives the largest, 6000 ms.
- R12: `good_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle time base pulse, one per ms |
| pin_mode | input | 1 | 1: period from `pin_sel`, 0: from `mult`/`presc` |
| pin_sel | input | 2 | Pin-driven period select |
| mode_timeout | input | 1 | 0: window mode, 1: timeout mode |
| mult | input | 3 | Period multiplier code |
| presc | input | 2 | Period prescaler code |
| trig_in | input | 1 | Asynchronous trigger, serviced on a rising edge |
| svc_wr | input | 1 | Single-cycle service strobe |
| good_o | output | 1 | One-cycle pulse for a correct service |
| err_o | output | 1 | One-cycle pulse for an early service or an expiry |

## Verification
The clocked properties assume that the configuration inputs stay still while the timer runs. A shrinking period could otherwise leave the count beyond the new limit. The bench therefore changes configuration only while reset is held. The bench also assumes that `svc_wr` and `tick_ms` are synchronous, and that `trig_in` changes are spaced further apart than the synchroniser depth. To respect this, it drives every input at the falling clock edge and holds each `trig_in` level for many cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;

    localparam int unsigned WD_LARGEST_MS = 20240;

    // Period in ms for the register-style codes; reserved codes give the largest.
    function automatic int unsigned spi_period_ms(input logic [2:0] m, input logic [1:0] p);
        int unsigned step;
        step = int'(p) + 1;
        case (m)
            3'd0:    return 4 * step;
            3'd1:    return 32 * step;
            3'd2:    return 128 * step;
            3'd3:    begin
                case (p)
                    2'd0:    return 256;
                    2'd1:    return 384;
                    2'd2:    return 512;
                    default: return 768;
                endcase
            end
            3'd4:    return 512 * step;
            3'd5:    return 2048 * step;
            3'd6:    return (p == 2'd0) ? 10240 : WD_LARGEST_MS;
            default: return WD_LARGEST_MS;
        endcase
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned PIN_SHORT = 40,
    parameter int unsigned PIN_MID   = 600,
    parameter int unsigned PIN_LONG  = 6000
) (
    input  logic             pin_mode_i,
    input  logic [1:0]       pin_sel_i,
    input  logic [2:0]       mult_i,
    input  logic [1:0]       presc_i,
    output logic [CNT_W-1:0] period_o
);
    import wdt_pkg::*;

    int unsigned ms;

    always_comb begin
        if (pin_mode_i) begin
            case (pin_sel_i)
                2'd0:    ms = PIN_SHORT;
                2'd1:    ms = PIN_MID;
                default: ms = PIN_LONG;
            endcase
        end else begin
            ms = spi_period_ms(mult_i, presc_i);
        end
        period_o = ms[CNT_W-1:0];
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             svc_i,
    input  logic             mode_to_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             good_o,
    output logic             err_o
);
    import wdt_pkg::*;

    typedef struct packed {
        wd_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             good;
        logic             err;
    } core_s;

    core_s d, q;
    logic [CNT_W-1:0] half;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        half    = period_i >> 1;
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        d       = q;
        d.good  = 1'b0;
        d.err   = 1'b0;
        case (q.state)
            WD_IDLE: begin
                if (svc_i) begin
                    d.state = WD_RUN;
                    d.cnt   = '0;
                end
            end
            default: begin
                if (svc_i) begin
                    d.cnt = '0;
                    if (!mode_to_i && (q.cnt < half)) d.err  = 1'b1;
                    else                               d.good = 1'b1;
                end else if (tick_i) begin
                    if (cnt_inc >= {1'b0, period_i}) begin
                        d.err = 1'b1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: WD_IDLE, cnt: '0, good: 1'b0, err: 1'b0};
        else        q <= d;
    end

    assign good_o = q.good;
    assign err_o  = q.err;

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_o && err_o));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == WD_IDLE) |-> (!good_o && !err_o));
    // R1
    stay_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == WD_RUN) |=> (q.state == WD_RUN));
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o || err_o) |-> ((q.state == WD_RUN) && (q.cnt == '0)));
    // R4
    early_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == WD_RUN) && svc_i && !mode_to_i && (q.cnt < half)) |=> err_o);
    // R7
    timeout_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == WD_RUN) && svc_i && mode_to_i) |=> good_o);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
    parameter int unsigned CNT_W       = 15,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PIN_SHORT   = 40,
    parameter int unsigned PIN_MID     = 600,
    parameter int unsigned PIN_LONG    = 6000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       pin_mode,
    input  logic [1:0] pin_sel,
    input  logic       mode_timeout,
    input  logic [2:0] mult,
    input  logic [1:0] presc,
    input  logic       trig_in,
    input  logic       svc_wr,
    output logic       good_o,
    output logic       err_o
);
    logic             trig_rise;
    logic             svc;
    logic [CNT_W-1:0] period;

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_in),
        .rise_o  (trig_rise)
    );

    wdt_period_sel #(
        .CNT_W     (CNT_W),
        .PIN_SHORT (PIN_SHORT),
        .PIN_MID   (PIN_MID),
        .PIN_LONG  (PIN_LONG)
    ) u_period (
        .pin_mode_i (pin_mode),
        .pin_sel_i  (pin_sel),
        .mult_i     (mult),
        .presc_i    (presc),
        .period_o   (period)
    );

    assign svc = trig_rise | svc_wr;

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_ms),
        .svc_i     (svc),
        .mode_to_i (mode_timeout),
        .period_i  (period),
        .good_o    (good_o),
        .err_o     (err_o)
    );

endmodule

// File: tb/svc_watchdog_test.sv
module svc_watchdog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b1;
    logic       pin_mode = 1'b0;
    logic [1:0] pin_sel = 2'd0;
    logic       mode_timeout = 1'b0;
    logic [2:0] mult = 3'd0;
    logic [1:0] presc = 2'd0;
    logic       trig_in = 1'b0;
    logic       svc_wr = 1'b0;
    logic       good_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    int stray = 0;
    int both_seen = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    localparam int unsigned TAB [32] = '{
        4, 8, 12, 16,   32, 64, 96, 128,   128, 256, 384, 512,   256, 384, 512, 768,
        512, 1024, 1536, 2048,   2048, 4096, 6144, 8192,
        10240, 20240, 20240, 20240,   20240, 20240, 20240, 20240};

    svc_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pin_mode(pin_mode),
        .pin_sel(pin_sel), .mode_timeout(mode_timeout), .mult(mult), .presc(presc),
        .trig_in(trig_in), .svc_wr(svc_wr), .good_o(good_o), .err_o(err_o));

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tick_div <= 1) tick_ms = 1'b1;
        else begin
            tick_cnt = tick_cnt + 1;
            tick_ms  = (tick_cnt % tick_div) == 0;
        end
        if (rst_n && good_o && err_o) both_seen = both_seen + 1;
    end

    function automatic int unsigned exp_period(input bit pm, input logic [1:0] ps,
                                               input logic [2:0] m, input logic [1:0] p);
        if (pm) return (ps == 2'd0) ? 40 : (ps == 2'd1) ? 600 : 6000;
        return TAB[{m, p}];
    endfunction

    // 1: good expected, 2: error expected
    function automatic int exp_result(input bit to_mode, input int n, input int unsigned per);
        if (to_mode) return 1;
        return (n < int'(per / 2)) ? 2 : 1;
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_svc(output int res);
        svc_wr = 1'b1;
        @(negedge clk);
        svc_wr = 1'b0;
        res = {30'd0, err_o, good_o};
    endtask

    task automatic wait_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (good_o || err_o) stray++;
        end
    endtask

    // reset, then start timer with a first service that must give no pulse
    task automatic start(input string req);
        int r;
        do_reset();
        stray = 0;
        do_svc(r);
        chk_eq(req, "first service pulse", r, 0);
    endtask

    // expiry of a full period with no service
    task automatic expiry_test(input string req, input int unsigned per);
        wait_quiet(int'(per) - 1);
        chk_eq(req, "quiet before expiry", stray, 0);
        @(negedge clk);
        chk_eq(req, "err at expiry", {31'd0, err_o}, 1);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin : main
        int r;
        int unsigned per;
        int n;
        void'($urandom(32'd4242));

        // R1: reset state and idle behaviour
        do_reset();
        chk_eq("R1", "good after reset", {31'd0, good_o}, 0);
        chk_eq("R1", "err after reset", {31'd0, err_o}, 0);
        stray = 0;
        wait_quiet(50);
        chk_eq("R1", "idle pulses", stray, 0);

        // R6 and R9: window mode expiry, multiplier 000 prescaler 11
        mult = 3'd0; presc = 2'd3;
        start("R1");
        expiry_test("R6", 16);

        // R8: after an error a fresh closed window, so immediate service is early
        do_svc(r);
        chk_eq("R8", "service right after error", r, 2);

        // R4 and R5: window boundaries, period 128
        mult = 3'd1; presc = 2'd3; per = 128;
        start("R4");
        wait_quiet(63);
        do_svc(r);
        chk_eq("R4", "service at P/2-1", r, 2);
        wait_quiet(64);
        do_svc(r);
        chk_eq("R5", "service at P/2", r, 1);
        wait_quiet(127);
        do_svc(r);
        chk_eq("R5", "service at P-1", r, 1);
        chk_eq("R5", "no stray pulse", stray, 0);

        // R7: timeout mode accepts at zero elapsed and restarts (R8)
        mode_timeout = 1'b1;
        start("R7");
        do_svc(r);
        chk_eq("R7", "service at 0", r, 1);
        wait_quiet(127);
        do_svc(r);
        chk_eq("R8", "service at P-1 after restart", r, 1);
        expiry_test("R6", per);

        // R2: trigger pin edge, three-cycle latency, level ignored
        mult = 3'd2; presc = 2'd3;
        start("R2");
        wait_quiet(5);
        trig_in = 1'b1;
        wait_quiet(2);
        chk_eq("R2", "early trig pulse", stray, 0);
        @(negedge clk);
        chk_eq("R2", "good three cycles after rise", {31'd0, good_o}, 1);
        stray = 0;
        wait_quiet(20);
        chk_eq("R2", "held high level", stray, 0);
        trig_in = 1'b0;
        wait_quiet(20);
        chk_eq("R2", "falling edge", stray, 0);

        // R3: time follows tick pulses, one every third cycle
        mode_timeout = 1'b0; mult = 3'd0; presc = 2'd0;
        tick_div = 3;
        start("R3");
        n = 0;
        while (!err_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        n_chk++;
        if (n < 10 || n > 14) begin
            n_bad++;
            $display("FAIL R3 cycles to expiry: actual %0d expected 12", n);
        end
        tick_div = 1;

        // R10: reserved codes give the largest legal period
        mult = 3'd6; presc = 2'd2;
        start("R10");
        expiry_test("R10", 20240);
        mult = 3'd7; presc = 2'd1; mode_timeout = 1'b1;
        start("R10");
        expiry_test("R10", 20240);
        mode_timeout = 1'b0;

        // R11: pin-driven periods
        pin_mode = 1'b1; pin_sel = 2'd0;
        start("R11");
        expiry_test("R11", 40);
        pin_sel = 2'd1;
        start("R11");
        wait_quiet(299);
        do_svc(r);
        chk_eq("R11", "600 ms early edge", r, 2);
        wait_quiet(300);
        do_svc(r);
        chk_eq("R11", "600 ms open edge", r, 1);
        pin_sel = 2'd3;
        start("R11");
        expiry_test("R11", 6000);
        pin_mode = 1'b0;

        // R9, R4, R5, R7: random configurations and service times
        for (int k = 0; k < 30; k++) begin
            mode_timeout = 1'($urandom_range(1, 0));
            mult  = 3'($urandom_range(3, 0));
            presc = 2'($urandom_range(3, 0));
            per   = exp_period(1'b0, 2'd0, mult, presc);
            n     = int'($urandom_range(per - 1, 0));
            start("R9");
            wait_quiet(n);
            do_svc(r);
            chk_eq("R9", "random service verdict", r, exp_result(mode_timeout, n, per));
            chk_eq("R9", "random quiet wait", stray, 0);
        end

        // R12: never both pulses together
        chk_eq("R12", "cycles with both pulses", both_seen, 0);

        summary();
        $finish;
    end

endmodule